// File: doc/BRIEF.md
# I2C memory transaction sequencer

This block drives a byte-level I2C engine through complete random-access transactions with a memory-style slave. A requester supplies a 7-bit chip address, a data address of one to `ADDR_BYTES` bytes, a byte count and an operation code. The sequencer then issues one framed byte command at a time and waits for the engine's completion before it sends the next. Write payload is pulled from a valid/ready byte stream. Read payload is pushed out as single-cycle strobes.

A transaction starts with an engine reset pulse. The chip is addressed for writing and the data address is sent, most significant byte first. A write continues with its payload bytes. A read first re-addresses the chip for reading behind a repeated START and then collects its bytes. The transaction ends with a second engine reset and a `done` pulse that carries a status code. A probe operation only checks that a chip is present: it addresses the chip for reading and takes one byte. The first failing byte command ends the transaction at once.

Top module: `i2cmem_seq`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` rises on the cycle after acceptance and stays high through the single cycle in which `done` is high. Requests raised while `busy` is high are ignored and start no transaction.
- R2: Every legal transaction pulses `eng_rst` for one cycle before its first command and again for one cycle after its last command, whether the transaction succeeds or fails. No command is issued in a cycle in which `eng_rst` is high.
- R3: Read and write transactions open with a command that has start=1, stop=0, read=0 and data = {chip, 1'b0}.
- R4: The data address follows as `req_alen` commands with start=0, read=0 and data taken from `req_addr` bytes alen-1 down to 0 (byte k = bits 8k+7..8k). Only the case in R7 sets stop on an address byte.
- R5: A read then sends start=1, data={chip, 1'b1}, followed by `req_count` commands with read=1 and data=0. All but the last have nack=0 and stop=0. The last has nack=1 and stop=1. Each received byte appears once on `rd_data` with a one-cycle `rd_valid`.
- R6: A write sends `req_count` payload commands with read=0. Each takes its data from one `wr_valid`/`wr_ready` handshake, in stream order. Only the last payload command has stop=1.
- R7: A write with `req_count`=0 sets stop=1 on its final address byte and sends no payload.
- R8: A probe (op 2) ignores address, alen and count. It sends start=1 with data={chip, 1'b1}, then one read command with nack=1 and stop=1. It raises no `rd_valid`.
- R9: When an engine completion reports failure (`eng_ok`=0), no further command is issued. The transaction ends with status 1 (fail). A transaction without failures ends with status 0 (ok).
- R10: A request is illegal, and ends with status 2 with no `eng_rst` and no command, if any of these holds: op is 3, a read/write has alen of 0 or above `ADDR_BYTES`, or a read has count 0.
- R11: At most one command is outstanding. `eng_cmd_valid` is a one-cycle pulse, and the next one comes only after `eng_done`.
- R12: After reset `busy`, `done`, `eng_cmd_valid`, `eng_rst`, `wr_ready` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 2 | 0 write, 1 read, 2 probe, 3 illegal |
| req_chip | input | 7 | 7-bit chip address |
| req_addr | input | 8*ADDR_BYTES | Data address |
| req_alen | input | clog2(ADDR_BYTES+1) | Number of address bytes |
| req_count | input | CNT_W | Payload byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 fail, 2 illegal; valid with done |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload available |
| wr_ready | output | 1 | Payload byte taken this cycle |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | rd_data valid strobe |
| eng_rst | output | 1 | Engine reset pulse |
| eng_cmd_valid | output | 1 | Byte command strobe |
| eng_cmd_start | output | 1 | Precede byte with START |
| eng_cmd_stop | output | 1 | Follow byte with STOP |
| eng_cmd_read | output | 1 | Receive a byte instead of sending |
| eng_cmd_nack | output | 1 | Answer the received byte with NACK |
| eng_cmd_data | output | 8 | Byte to send |
| eng_done | input | 1 | Engine finished the command |
| eng_ok | input | 1 | ACK seen or byte received |
| eng_rx_data | input | 8 | Byte received by the engine |

## Verification
The assertions watch several rules on every cycle. They check the single-command handshake, the silence of the command strobe during engine resets, the one-cycle `done` that `busy` always covers, and the framing rules: START never paired with STOP or read, and NACK only on a final read carrying STOP. They also check that the byte counters never decrement past zero and that read strobes only follow engine completions. The exact order of command bytes can only be shown by the bench scenarios, which compare each transaction against a sequence built from the request. These scenarios also cover MSB-first address order, the payload taken from the stream, the abort point after an injected failure, the reset pulse count, illegal-request rejection and the fact that requests made while busy are ignored.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_PROBE = 2'd2,
      OP_BAD   = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_FAIL    = 2'd1,
      ST_ILLEGAL = 2'd2,
      ST_RSVD    = 2'd3
   } status_e;

   typedef enum logic [2:0] {
      PH_CHIPW = 3'd0,
      PH_ADDR  = 3'd1,
      PH_CHIPR = 3'd2,
      PH_WDATA = 3'd3,
      PH_RDATA = 3'd4
   } phase_e;

   typedef struct packed {
      logic       start;
      logic       stop;
      logic       rd;
      logic       nack;
      logic [7:0] data;
   } bytecmd_t;

endpackage

// File: rtl/i2cmem_dcount.sv
module i2cmem_dcount #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] value,
   output logic         at_zero,
   output logic         at_one
);

   generate
      if (W < 1) begin : g_bad_width
         $error("i2cmem_dcount: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign value   = cnt_q;
   assign at_zero = (cnt_q == '0);
   assign at_one  = (cnt_q == W'(1));

   // counters are only stepped while work remains (R5, R6)
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dec && !load |-> !at_zero);

endmodule

// File: rtl/i2cmem_framer.sv
module i2cmem_framer
   import i2cmem_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int IDX_W      = 2
) (
   input  phase_e                    phase,
   input  op_e                       op,
   input  logic [6:0]                chip,
   input  logic [8*ADDR_BYTES-1:0]   addr,
   input  logic [IDX_W-1:0]          idx,
   input  logic                      idx_last,
   input  logic [7:0]                wbyte,
   input  logic                      data_last,
   input  logic                      no_data,
   output bytecmd_t                  cmd
);

   logic [7:0] addr_b [ADDR_BYTES];
   logic [7:0] addr_sel;

   generate
      for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_slice
         assign addr_b[k] = addr[8*k +: 8];
      end
   endgenerate

   always_comb begin
      addr_sel = 8'h00;
      for (int k = 0; k < ADDR_BYTES; k++) begin
         if (idx == IDX_W'(k)) addr_sel = addr_b[k];
      end
   end

   always_comb begin
      cmd = '0;
      unique case (phase)
         PH_CHIPW: begin
            cmd.start = 1'b1;
            cmd.data  = {chip, 1'b0};
         end
         PH_ADDR: begin
            cmd.data = addr_sel;
            cmd.stop = (op == OP_WRITE) && no_data && idx_last;
         end
         PH_CHIPR: begin
            cmd.start = 1'b1;
            cmd.data  = {chip, 1'b1};
         end
         PH_WDATA: begin
            cmd.data = wbyte;
            cmd.stop = data_last;
         end
         PH_RDATA: begin
            cmd.rd   = 1'b1;
            cmd.nack = data_last;
            cmd.stop = data_last;
         end
         default: cmd = '0;
      endcase
   end

endmodule

// File: rtl/i2cmem_seq.sv
module i2cmem_seq
   import i2cmem_pkg::*;
#(
   parameter int ADDR_BYTES = 3,
   parameter int CNT_W      = 8,
   localparam int IDX_W     = $clog2(ADDR_BYTES + 1),
   localparam int ADDR_W    = 8 * ADDR_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [6:0]        req_chip,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [IDX_W-1:0]  req_alen,
   input  logic [CNT_W-1:0]  req_count,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              eng_rst,
   output logic              eng_cmd_valid,
   output logic              eng_cmd_start,
   output logic              eng_cmd_stop,
   output logic              eng_cmd_read,
   output logic              eng_cmd_nack,
   output logic [7:0]        eng_cmd_data,
   input  logic              eng_done,
   input  logic              eng_ok,
   input  logic [7:0]        eng_rx_data
);

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 4) begin : g_bad_abytes
         $error("i2cmem_seq: ADDR_BYTES must be 1 to 4");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("i2cmem_seq: CNT_W must be 1 to 16");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_PRST, S_WGET, S_ISSUE, S_WAIT, S_POST, S_DONE
   } state_e;

   state_e             state_q;
   phase_e             phase_q;
   op_e                op_q;
   logic [6:0]         chip_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [IDX_W-1:0]   alen_q;
   logic [7:0]         wbyte_q;
   status_e            status_q;
   logic [7:0]         rd_data_q;
   logic               rd_valid_q;

   // request decode
   op_e  req_op_e;
   logic alen_ok;
   logic req_bad;
   logic accept;

   assign req_op_e = op_e'(req_op);
   assign alen_ok  = (req_alen != '0) && (int'(req_alen) <= ADDR_BYTES);
   assign req_bad  = (req_op_e == OP_BAD)
                  || ((req_op_e != OP_PROBE) && !alen_ok)
                  || ((req_op_e == OP_READ) && (req_count == '0));
   assign accept   = req_valid && (state_q == S_IDLE);

   // counters
   logic             idx_load, idx_dec, idx_zero, idx_one;
   logic [IDX_W-1:0] idx_val;
   logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
   logic [CNT_W-1:0] cnt_val, cnt_init;

   logic step_ok;
   assign step_ok = (state_q == S_WAIT) && eng_done && eng_ok;

   assign idx_load = step_ok && (phase_q == PH_CHIPW);
   assign idx_dec  = step_ok && (phase_q == PH_ADDR) && !idx_zero;
   assign cnt_init = (req_op_e == OP_PROBE) ? CNT_W'(1) : req_count;
   assign cnt_load = accept;
   assign cnt_dec  = step_ok && ((phase_q == PH_WDATA) || (phase_q == PH_RDATA))
                  && !cnt_one;

   i2cmem_dcount #(.W(IDX_W)) u_idx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idx_load),
      .load_val (alen_q - IDX_W'(1)),
      .dec      (idx_dec),
      .value    (idx_val),
      .at_zero  (idx_zero),
      .at_one   (idx_one)
   );

   i2cmem_dcount #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_init),
      .dec      (cnt_dec),
      .value    (cnt_val),
      .at_zero  (cnt_zero),
      .at_one   (cnt_one)
   );

   // command framing
   bytecmd_t cmd;

   i2cmem_framer #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_framer (
      .phase     (phase_q),
      .op        (op_q),
      .chip      (chip_q),
      .addr      (addr_q),
      .idx       (idx_val),
      .idx_last  (idx_zero),
      .wbyte     (wbyte_q),
      .data_last (cnt_one),
      .no_data   (cnt_zero),
      .cmd       (cmd)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         phase_q    <= PH_CHIPW;
         op_q       <= OP_WRITE;
         chip_q     <= '0;
         addr_q     <= '0;
         alen_q     <= '0;
         wbyte_q    <= '0;
         status_q   <= ST_OK;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (accept) begin
                  op_q   <= req_op_e;
                  chip_q <= req_chip;
                  addr_q <= req_addr;
                  alen_q <= req_alen;
                  if (req_bad) begin
                     status_q <= ST_ILLEGAL;
                     state_q  <= S_DONE;
                  end else begin
                     status_q <= ST_OK;
                     phase_q  <= (req_op_e == OP_PROBE) ? PH_CHIPR : PH_CHIPW;
                     state_q  <= S_PRST;
                  end
               end
            end
            S_PRST:  state_q <= S_ISSUE;
            S_WGET: begin
               if (wr_valid) begin
                  wbyte_q <= wr_data;
                  state_q <= S_ISSUE;
               end
            end
            S_ISSUE: state_q <= S_WAIT;
            S_WAIT: begin
               if (eng_done) begin
                  if (!eng_ok) begin
                     status_q <= ST_FAIL;
                     state_q  <= S_POST;
                  end else begin
                     unique case (phase_q)
                        PH_CHIPW: begin
                           phase_q <= PH_ADDR;
                           state_q <= S_ISSUE;
                        end
                        PH_ADDR: begin
                           if (!idx_zero) begin
                              state_q <= S_ISSUE;
                           end else if (op_q == OP_READ) begin
                              phase_q <= PH_CHIPR;
                              state_q <= S_ISSUE;
                           end else if (cnt_zero) begin
                              state_q <= S_POST;
                           end else begin
                              phase_q <= PH_WDATA;
                              state_q <= S_WGET;
                           end
                        end
                        PH_CHIPR: begin
                           phase_q <= PH_RDATA;
                           state_q <= S_ISSUE;
                        end
                        PH_WDATA: begin
                           state_q <= cnt_one ? S_POST : S_WGET;
                        end
                        PH_RDATA: begin
                           if (op_q != OP_PROBE) begin
                              rd_data_q  <= eng_rx_data;
                              rd_valid_q <= 1'b1;
                           end
                           state_q <= cnt_one ? S_POST : S_ISSUE;
                        end
                        default: state_q <= S_POST;
                     endcase
                  end
               end
            end
            S_POST:  state_q <= S_DONE;
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy          = (state_q != S_IDLE);
   assign done          = (state_q == S_DONE);
   assign status        = status_q;
   assign wr_ready      = (state_q == S_WGET);
   assign rd_data       = rd_data_q;
   assign rd_valid      = rd_valid_q;
   assign eng_rst       = (state_q == S_PRST) || (state_q == S_POST);
   assign eng_cmd_valid = (state_q == S_ISSUE);
   assign eng_cmd_start = cmd.start;
   assign eng_cmd_stop  = cmd.stop;
   assign eng_cmd_read  = cmd.rd;
   assign eng_cmd_nack  = cmd.nack;
   assign eng_cmd_data  = cmd.data;

   // protocol checks
   assert_done_in_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_rst_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |-> !eng_cmd_valid && !wr_ready);
   assert_start_framing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid && eng_cmd_start |-> !eng_cmd_stop && !eng_cmd_read);
   assert_nack_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid && eng_cmd_nack |-> eng_cmd_stop && eng_cmd_read);
   assert_rd_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(eng_done) && $past(eng_ok));
   assert_single_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |=> !eng_cmd_valid);
   assert_idle_no_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !eng_cmd_valid && !eng_rst && !wr_ready);

endmodule

// File: tb/i2cmem_seq_bench.sv
`timescale 1ns/1ps
module i2cmem_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [6:0]  req_chip = '0;
   logic [23:0] req_addr = '0;
   logic [1:0]  req_alen = '0;
   logic [7:0]  req_count = '0;
   logic        busy, done;
   logic [1:0]  status;
   logic [7:0]  wr_data;
   logic        wr_valid;
   logic        wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        eng_rst, eng_cmd_valid, eng_cmd_start, eng_cmd_stop;
   logic        eng_cmd_read, eng_cmd_nack;
   logic [7:0]  eng_cmd_data;
   logic        eng_done, eng_ok;
   logic [7:0]  eng_rx_data;

   always #2.5 clk = ~clk;

   i2cmem_seq u_i2cmem_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_chip(req_chip),
      .req_addr(req_addr), .req_alen(req_alen), .req_count(req_count),
      .busy(busy), .done(done), .status(status),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .eng_rst(eng_rst), .eng_cmd_valid(eng_cmd_valid),
      .eng_cmd_start(eng_cmd_start), .eng_cmd_stop(eng_cmd_stop),
      .eng_cmd_read(eng_cmd_read), .eng_cmd_nack(eng_cmd_nack),
      .eng_cmd_data(eng_cmd_data),
      .eng_done(eng_done), .eng_ok(eng_ok), .eng_rx_data(eng_rx_data)
   );

   int checks = 0;
   int fails  = 0;

   // engine and stream model: logs {start,stop,read,nack,data}
   logic [11:0] cmd_log [256];
   logic [7:0]  rd_log  [256];
   int          ncmd = 0, nrd = 0, nrst = 0, wcnt = 0;
   int          fail_abs = -1;

   initial begin
      int  pend;
      int  cur;
      bit  taken;
      pend = 0; cur = 0; taken = 0;
      eng_done = 0; eng_ok = 0; eng_rx_data = 0;
      wr_valid = 1; wr_data = 8'hC0;
      forever begin
         @(negedge clk);
         if (eng_done) eng_done = 0;
         if (taken) begin
            wcnt++;
            wr_data = 8'(8'hC0 + wcnt);
            taken = 0;
         end
         if (wr_ready) taken = 1;
         if (eng_rst) nrst++;
         if (rd_valid) begin
            rd_log[nrd[7:0]] = rd_data;
            nrd++;
         end
         if (eng_cmd_valid) begin
            cmd_log[ncmd[7:0]] = {eng_cmd_start, eng_cmd_stop, eng_cmd_read,
                                  eng_cmd_nack, eng_cmd_data};
            cur = ncmd;
            ncmd++;
            pend = 3;
         end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               eng_done    = 1;
               eng_ok      = (cur != fail_abs);
               eng_rx_data = 8'h5A ^ 8'(cur);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  op;
      logic [6:0]  chip;
      logic [23:0] addr;
      logic [1:0]  alen;
      logic [7:0]  cnt;
      logic [7:0]  fail;
      logic [31:0] tag;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 7'h50, 24'h000012, 2'd1, 8'd2, 8'hFF, "R6  "},
      '{2'd1, 7'h50, 24'h001234, 2'd2, 8'd3, 8'hFF, "R5  "},
      '{2'd1, 7'h2A, 24'hABCDEF, 2'd3, 8'd1, 8'hFF, "R4  "},
      '{2'd2, 7'h3C, 24'h777777, 2'd0, 8'd0, 8'hFF, "R8  "},
      '{2'd0, 7'h11, 24'h0A0B0C, 2'd3, 8'd0, 8'hFF, "R7  "},
      '{2'd1, 7'h50, 24'h00BEEF, 2'd2, 8'd2, 8'd1,  "R9  "},
      '{2'd0, 7'h50, 24'h000044, 2'd1, 8'd3, 8'd3,  "R9  "},
      '{2'd2, 7'h3D, 24'h000000, 2'd1, 8'd1, 8'd0,  "R9  "},
      '{2'd1, 7'h50, 24'h000010, 2'd1, 8'd0, 8'hFF, "R10 "},
      '{2'd3, 7'h50, 24'h000010, 2'd1, 8'd1, 8'hFF, "R10 "},
      '{2'd0, 7'h50, 24'h000010, 2'd0, 8'd1, 8'hFF, "R10 "},
      '{2'd1, 7'h68, 24'h000075, 2'd1, 8'd1, 8'd3,  "R3  "}
   };

   task automatic run_vec(input vec_t v);
      logic [11:0] exp_c [32];
      bit          exp_rdc [32];
      int          n, nexp, cb, rb, sb, wb, nrd_exp, waited;
      bit          illegal, ok;
      logic [1:0]  exp_st;
      string       tg;
      tg = string'(v.tag);
      n = 0;
      illegal = (v.op == 2'd3) || (v.op != 2'd2 && (v.alen == 0 || v.alen > 3))
             || (v.op == 2'd1 && v.cnt == 0);
      cb = ncmd; rb = nrd; sb = nrst; wb = wcnt;
      if (!illegal) begin
         if (v.op == 2'd2) begin
            exp_c[0] = {4'b1000, v.chip, 1'b1}; exp_rdc[0] = 0;
            exp_c[1] = {4'b0111, 8'h00};        exp_rdc[1] = 0;
            n = 2;
         end else begin
            exp_c[n] = {4'b1000, v.chip, 1'b0}; exp_rdc[n] = 0; n++;
            for (int i = int'(v.alen) - 1; i >= 0; i--) begin
               exp_c[n] = {1'b0, (v.op == 2'd0 && v.cnt == 0 && i == 0), 2'b00,
                           v.addr[8*i +: 8]};
               exp_rdc[n] = 0; n++;
            end
            if (v.op == 2'd1) begin
               exp_c[n] = {4'b1000, v.chip, 1'b1}; exp_rdc[n] = 0; n++;
               for (int j = 0; j < int'(v.cnt); j++) begin
                  bit last = (j == int'(v.cnt) - 1);
                  exp_c[n] = {1'b0, last, 1'b1, last, 8'h00}; exp_rdc[n] = 1; n++;
               end
            end else begin
               for (int j = 0; j < int'(v.cnt); j++) begin
                  bit last = (j == int'(v.cnt) - 1);
                  exp_c[n] = {1'b0, last, 2'b00, 8'(8'hC0 + wb + j)};
                  exp_rdc[n] = 0; n++;
               end
            end
         end
      end
      if (!illegal && v.fail != 8'hFF && int'(v.fail) < n) begin
         nexp = int'(v.fail) + 1; exp_st = 2'd1;
      end else begin
         nexp = n; exp_st = illegal ? 2'd2 : 2'd0;
      end
      fail_abs = (v.fail == 8'hFF) ? -1 : cb + int'(v.fail);

      @(negedge clk);
      req_op = v.op; req_chip = v.chip; req_addr = v.addr;
      req_alen = v.alen; req_count = v.cnt; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      waited = 0;
      while (!done && waited < 3000) begin
         @(negedge clk);
         waited++;
      end
      chk(done, tg, "done seen", {31'd0, done}, 1);
      chk(status == exp_st, tg, "status", {30'd0, status}, {30'd0, exp_st});
      @(negedge clk);
      chk(!busy, "R1", "busy after done", {31'd0, busy}, 0);
      chk(ncmd - cb == nexp, tg, "command count", ncmd - cb, nexp);
      ok = 1;
      for (int k = 0; k < nexp && k < ncmd - cb; k++) begin
         if (cmd_log[8'(cb + k)] !== exp_c[k]) begin
            ok = 0;
            chk(0, tg, $sformatf("command %0d", k), {20'd0, cmd_log[8'(cb + k)]},
                {20'd0, exp_c[k]});
         end
      end
      if (ok) chk(1, tg, "command sequence", 0, 0);
      chk(nrst - sb == (illegal ? 0 : 2), "R2", "engine reset pulses", nrst - sb,
          illegal ? 0 : 2);
      nrd_exp = 0;
      for (int k = 0; k < nexp; k++) begin
         if (exp_rdc[k] && !(exp_st == 2'd1 && k == nexp - 1)) begin
            chk(rd_log[8'(rb + nrd_exp)] == (8'h5A ^ 8'(cb + k)), "R5", "read byte",
                {24'd0, rd_log[8'(rb + nrd_exp)]}, {24'd0, 8'h5A ^ 8'(cb + k)});
            nrd_exp++;
         end
      end
      chk(nrd - rb == nrd_exp, (v.op == 2'd2) ? "R8" : "R5", "read strobes",
          nrd - rb, nrd_exp);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int cb;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(!busy && !done && !eng_cmd_valid && !eng_rst && !wr_ready && !rd_valid,
          "R12", "outputs in reset",
          {26'd0, busy, done, eng_cmd_valid, eng_rst, wr_ready, rd_valid}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!busy && !eng_cmd_valid, "R12", "idle after reset",
          {30'd0, busy, eng_cmd_valid}, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R1: requests made while busy are ignored
      cb = ncmd;
      fail_abs = -1;
      @(negedge clk);
      req_op = 2'd1; req_chip = 7'h21; req_addr = 24'h000005; req_alen = 2'd1;
      req_count = 8'd2; req_valid = 1;
      @(negedge clk);
      req_op = 2'd0; req_chip = 7'h7F; req_count = 8'd4;
      chk(busy, "R1", "busy after accept", {31'd0, busy}, 1);
      repeat (4) @(negedge clk);
      req_valid = 0;
      for (int w = 0; w < 3000 && !done; w++) @(negedge clk);
      repeat (30) @(negedge clk);
      chk(ncmd - cb == 5, "R1", "commands of one transaction", ncmd - cb, 5);
      chk(cmd_log[8'(cb)] == {4'b1000, 7'h21, 1'b0}, "R1", "first chip byte",
          {20'd0, cmd_log[8'(cb)]}, {20'd0, 4'b1000, 7'h21, 1'b0});
      chk(!busy, "R1", "idle after ignored request", {31'd0, busy}, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule